// File: doc/BRIEF.md
# Modem Status Register

This block keeps the modem-status byte of a serial port. Four modem input lines are brought into the clock domain through a chain of synchronising flops. Their settled levels sit in the upper nibble of the byte. The lower nibble holds one change flag per line. A flag is raised when the line's synchronised level differs from the level already stored. The ring line is the exception: its flag is raised only on a transition from active to inactive.

The host sees the whole byte combinationally on `rd_data`. A read strobe clears the change flags on the following edge. A host write replaces the change flags with the low nibble of the written byte and leaves the level bits untouched. This lets software raise a modem-status interrupt by itself. The interrupt output is high whenever any change flag is set.

Top module: `modem_status_reg`

## Requirements
- R1: During and right after reset, with all lines low, `rd_data` is 0x00 and `irq` is low.
- R2: A change on the clear-to-send line appears in bit 4 on the third rising edge after the change, and on that same edge it sets bit 0.
- R3: The data-set-ready level is held in bit 5 and the carrier-detect level in bit 7. A change on either line sets bit 1 or bit 3 respectively, with the same three-edge latency as R2.
- R4: Bit 6 holds the ring level. Bit 2 is set only when the stored ring level goes from 1 to 0. A rise from 0 to 1 leaves bit 2 unchanged.
- R5: While the lines are steady and there is no host access, the change flags keep their value.
- R6: A write (`wr_en`) loads bits 3:0 from `wr_data[3:0]` on the next edge and leaves bits 7:4 unchanged.
- R7: `irq` is high exactly when any of bits 3:0 is 1. This includes flags set by a host write.
- R8: In a read cycle (`rd_en`), `rd_data` shows the current byte. On the next edge, bits 3:0 clear and bits 7:4 are kept.
- R9: A line change that reaches the register on the same edge as a read clear still leaves its flag set.
- R10: When a write and a read fall in the same cycle, the write wins and the written flags are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cts_i | input | 1 | Clear-to-send line, asynchronous |
| dsr_i | input | 1 | Data-set-ready line, asynchronous |
| dcd_i | input | 1 | Carrier-detect line, asynchronous |
| ri_i | input | 1 | Ring line, asynchronous; ignored when the ring option is off |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | 8 | Host write byte; only bits 3:0 are used |
| rd_en | input | 1 | Host read strobe; clears the change flags on the next edge |
| rd_data | output | 8 | Register byte: levels in 7:4, change flags in 3:0 |
| irq | output | 1 | Modem-status interrupt |

## Verification
A line change crosses two synchroniser flops and then the level register. Its level and change flag therefore show on the third rising edge after the input moves. Read clears and writes act on the first edge, and `irq` follows the flags with no extra delay. The bench drives at the falling edge and samples at the next falling edge. Directed cases count exactly two or three edges before comparing, which also catches a result that comes a cycle early or late. The random phase compares every cycle against a model that carries the same two-stage pipeline and is written from the requirements.

// File: rtl/msr_pkg.sv
package msr_pkg;
   localparam int NLINES    = 4;
   localparam int REG_W     = 2 * NLINES;
   // Line index i maps to level bit NLINES+i and to change flag bit i
   localparam int IDX_CTS   = 0;
   localparam int IDX_DSR   = 1;
   localparam int IDX_RING  = 2;
   localparam int IDX_DCD   = 3;

   typedef enum logic {
      EDGE_ANY  = 1'b0,
      EDGE_FALL = 1'b1
   } edge_mode_e;
endpackage

// File: rtl/msr_sync.sv
module msr_sync #(
   parameter int W      = 4,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] chain [STAGES];

   generate
      if (STAGES < 2) begin : g_bad
         $error("msr_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) chain[s] <= '0;
      end else begin
         chain[0] <= d;
         for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/msr_delta_cell.sv
module msr_delta_cell #(
   parameter msr_pkg::edge_mode_e MODE = msr_pkg::EDGE_ANY
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl_in,
   input  logic wr_en,
   input  logic wr_bit,
   input  logic rd_en,
   output logic lvl_q,
   output logic delta_q
);
   logic evt;
   logic base;

   generate
      if (MODE == msr_pkg::EDGE_FALL) begin : g_fall
         assign evt = lvl_q & ~lvl_in;
      end else begin : g_any
         assign evt = lvl_q ^ lvl_in;
      end
   endgenerate

   // Write has precedence over read clear; a new event always survives
   always_comb begin
      if (wr_en)      base = wr_bit;
      else if (rd_en) base = 1'b0;
      else            base = delta_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lvl_q   <= 1'b0;
         delta_q <= 1'b0;
      end else begin
         lvl_q   <= lvl_in;
         delta_q <= base | evt;
      end
   end
endmodule

// File: rtl/modem_status_reg.sv
module modem_status_reg #(
   parameter int SYNC_STAGES = 2,
   parameter bit HAS_RING    = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cts_i,
   input  logic       dsr_i,
   input  logic       dcd_i,
   input  logic       ri_i,
   input  logic       wr_en,
   input  logic [7:0] wr_data,
   input  logic       rd_en,
   output logic [7:0] rd_data,
   output logic       irq
);
   import msr_pkg::*;

   logic [NLINES-1:0] raw_lvl;
   logic [NLINES-1:0] sync_lvl;
   logic [NLINES-1:0] lvl_q;
   logic [NLINES-1:0] delta_q;
   logic              ring_src;

   generate
      if (REG_W != 8) begin : g_badw
         $error("modem_status_reg: register must be one byte");
      end
      if (HAS_RING) begin : g_ring
         assign ring_src = ri_i;
      end else begin : g_noring
         assign ring_src = 1'b0;
      end
   endgenerate

   always_comb begin
      raw_lvl           = '0;
      raw_lvl[IDX_CTS]  = cts_i;
      raw_lvl[IDX_DSR]  = dsr_i;
      raw_lvl[IDX_RING] = ring_src;
      raw_lvl[IDX_DCD]  = dcd_i;
   end

   msr_sync #(.W(NLINES), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (raw_lvl),
      .q     (sync_lvl)
   );

   generate
      for (genvar i = 0; i < NLINES; i++) begin : g_line
         localparam edge_mode_e M = (i == IDX_RING) ? EDGE_FALL : EDGE_ANY;
         msr_delta_cell #(.MODE(M)) u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .lvl_in  (sync_lvl[i]),
            .wr_en   (wr_en),
            .wr_bit  (wr_data[i]),
            .rd_en   (rd_en),
            .lvl_q   (lvl_q[i]),
            .delta_q (delta_q[i])
         );
      end
   endgenerate

   assign rd_data = {lvl_q, delta_q};
   assign irq     = |delta_q;

   logic unused_hi;
   assign unused_hi = ^wr_data[7:4];
endmodule

// File: rtl/msr_chk.sv
module msr_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       wr_en,
   input logic [7:0] wr_data,
   input logic       rd_en,
   input logic [7:0] rd_data,
   input logic       irq,
   input logic [3:0] sync_lvl
);
   logic quiet;
   assign quiet = (sync_lvl == rd_data[7:4]);

   // R3
   lvl_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> rd_data[7:4] == $past(sync_lvl));

   // R5
   flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en && !rd_en && quiet) |=> $stable(rd_data[3:0]));

   // R6
   wr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && quiet) |=> rd_data[3:0] == $past(wr_data[3:0]));

   // R7
   irq_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq == (rd_data[3:0] != 4'h0));

   // R8
   rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !wr_en && quiet) |=> rd_data[3:0] == 4'h0);

   // R9
   rd_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !wr_en && (sync_lvl[0] != rd_data[4])) |=> rd_data[0]);
endmodule

bind modem_status_reg msr_chk u_msr_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .wr_en    (wr_en),
   .wr_data  (wr_data),
   .rd_en    (rd_en),
   .rd_data  (rd_data),
   .irq      (irq),
   .sync_lvl (sync_lvl)
);

// File: tb/tb_modem_status_reg.sv
`timescale 1ns/1ps
module tb_modem_status_reg;
   logic       clk = 1'b0;
   logic       rst_n;
   logic       cts_i, dsr_i, dcd_i, ri_i;
   logic       wr_en, rd_en;
   logic [7:0] wr_data;
   logic [7:0] rd_data;
   logic       irq;

   int n_chk  = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   modem_status_reg dut (
      .clk(clk), .rst_n(rst_n), .cts_i(cts_i), .dsr_i(dsr_i), .dcd_i(dcd_i),
      .ri_i(ri_i), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
      .rd_data(rd_data), .irq(irq)
   );

   // Reference model: line order {dcd, ring, dsr, cts}, two sync stages
   logic [3:0] m_s1, m_s2, m_lvl, m_del;

   function automatic logic [3:0] line_events(logic [3:0] old_l, logic [3:0] new_l);
      logic [3:0] ev;
      ev    = old_l ^ new_l;
      ev[2] = old_l[2] & ~new_l[2];
      return ev;
   endfunction

   function automatic logic [3:0] next_flags(logic [3:0] cur, logic w, logic [3:0] wd,
                                             logic r, logic [3:0] ev);
      logic [3:0] b;
      b = w ? wd : (r ? 4'h0 : cur);
      return b | ev;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_s1 <= '0; m_s2 <= '0; m_lvl <= '0; m_del <= '0;
      end else begin
         m_s1  <= {dcd_i, ri_i, dsr_i, cts_i};
         m_s2  <= m_s1;
         m_lvl <= m_s2;
         m_del <= next_flags(m_del, wr_en, wr_data[3:0], rd_en, line_events(m_lvl, m_s2));
      end
   end

   task automatic check8(string tag, logic [7:0] act, logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
      end
   endtask

   task automatic check1(string tag, logic act, logic exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
      end
   endtask

   task automatic set_lines(logic [3:0] v);
      {dcd_i, ri_i, dsr_i, cts_i} = v;
   endtask

   task automatic cyc(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_read();
      rd_en = 1'b1;
      cyc(1);
      rd_en = 1'b0;
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      #1_000_000;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      void'($urandom(32'd20240611));
      rst_n = 1'b0; set_lines(4'h0);
      wr_en = 1'b0; rd_en = 1'b0; wr_data = 8'h00;
      cyc(3);
      check8("R1 reset byte", rd_data, 8'h00);
      check1("R1 reset irq", irq, 1'b0);
      rst_n = 1'b1;
      cyc(1);
      check8("R1 after reset", rd_data, 8'h00);

      // R2: clear-to-send rises, visible on third edge
      set_lines(4'b0001);
      cyc(2);
      check8("R2 not yet", rd_data, 8'h00);
      cyc(1);
      check8("R2 cts level and flag", rd_data, 8'h11);
      check1("R7 irq from flag", irq, 1'b1);

      // R8: read shows byte now, clears flags next edge
      rd_en = 1'b1;
      #1 check8("R8 read value", rd_data, 8'h11);
      cyc(1);
      rd_en = 1'b0;
      check8("R8 flags cleared", rd_data, 8'h10);
      check1("R7 irq cleared", irq, 1'b0);

      // R3: dsr and dcd rise together
      set_lines(4'b1011);
      cyc(3);
      check8("R3 dsr dcd", rd_data, 8'hBA);
      do_read();
      check8("R8 clear", rd_data, 8'hB0);

      // R4: ring rise gives no flag, fall gives bit 2
      set_lines(4'b1111);
      cyc(3);
      check8("R4 ring rise", rd_data, 8'hF0);
      set_lines(4'b1011);
      cyc(3);
      check8("R4 ring fall", rd_data, 8'hB4);
      do_read();

      // R5: steady lines hold
      cyc(8);
      check8("R5 steady", rd_data, 8'hB0);

      // R6: write loads low nibble only
      wr_en = 1'b1; wr_data = 8'h45;
      cyc(1);
      wr_en = 1'b0;
      check8("R6 write", rd_data, 8'hB5);
      check1("R7 irq after write", irq, 1'b1);
      wr_en = 1'b1; wr_data = 8'hF0;
      cyc(1);
      wr_en = 1'b0;
      check8("R6 write zero", rd_data, 8'hB0);
      check1("R7 irq after zero write", irq, 1'b0);

      // R9: cts falls; event lands on the read-clear edge
      set_lines(4'b1010);
      cyc(2);
      rd_en = 1'b1;
      cyc(1);
      rd_en = 1'b0;
      check8("R9 event kept", rd_data, 8'hA1);
      do_read();
      check8("R8 clear again", rd_data, 8'hA0);

      // R10: write and read in the same cycle
      wr_en = 1'b1; rd_en = 1'b1; wr_data = 8'h08;
      cyc(1);
      wr_en = 1'b0; rd_en = 1'b0;
      check8("R10 write wins", rd_data, 8'hA8);
      do_read();

      // Random phase against the model
      for (int k = 0; k < 4000; k++) begin
         check8("R3 levels", {4'h0, rd_data[7:4]}, {4'h0, m_lvl});
         check8("R5 flags", {4'h0, rd_data[3:0]}, {4'h0, m_del});
         check1("R7 irq", irq, |m_del);
         if (($urandom % 8) == 0) set_lines(4'($urandom));
         rd_en   = (($urandom % 5) == 0);
         wr_en   = (($urandom % 20) == 0);
         wr_data = 8'($urandom);
         cyc(1);
      end
      rd_en = 1'b0; wr_en = 1'b0;
      cyc(1);
      finish_run();
   end
endmodule